// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, side A and side B. For each direction it keeps one holding register, so a word seen on a bus can be kept and replayed to the other bus later. Each outgoing path has its own source select. The select either passes the live word from the opposite bus straight through, or presents the word held in the register for that direction. An active-low drive enable and a direction input decide which side, if either, is driven.

On-chip there are no tri-state nets. Each side therefore has an input vector, an output vector and an output-enable vector. The pad ring or the bus fabric combines these into a shared wire. The two capture strobes are ordinary signals sampled on the system clock, and a register loads on the first clock that sees its strobe high after it was low.

Capture does not depend on the drive controls. A word can be latched while neither side is driven and replayed later in stored mode. A build parameter inverts both the live and the stored path on the way out.

Top module: `regbus_xcvr`

## Requirements
- R1: Holding register A loads `a_in` on the clock where `cap_a_strb` is high and was low at the previous clock. While the strobe stays high, register A keeps its value.
- R2: Holding register B loads `b_in` on the clock where `cap_b_strb` is high and was low at the previous clock. While the strobe stays high, register B keeps its value.
- R3: Captures into either register take place for every value of `drv_en_n`, `dir_a2b` and the selects, including when neither side is driven. Both registers may load in the same clock.
- R4: When `drv_en_n` is 1, `a_oe` and `b_oe` are both all zeros.
- R5: When `drv_en_n` is 0 and `dir_a2b` is 1, `b_oe` is all ones and `a_oe` is all zeros. When `drv_en_n` is 0 and `dir_a2b` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R6: While B is driven, `b_out` equals the live `a_in` in the same cycle when `src_a2b` is 0, and equals register A when `src_a2b` is 1.
- R7: While A is driven, `a_out` equals the live `b_in` in the same cycle when `src_b2a` is 0, and equals register B when `src_b2a` is 1.
- R8: When a capture happens on a side whose stored path is driving, the output keeps the old stored word in the cycle of the strobe edge. The output shows the new word from the next cycle on.
- R9: With `INVERT` set to 1, every bit that reaches `a_out` or `b_out` is the complement of its source, on both the live and the stored path. With `INVERT` at 0, no bit is inverted.
- R10: Synchronous reset `rst` clears both registers and the strobe history to zero. A strobe that is still high when reset ends counts as a rising edge on the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en_n | input | 1 | Active-low drive enable; 1 isolates both sides |
| dir_a2b | input | 1 | 1: drive side B, 0: drive side A |
| src_a2b | input | 1 | Source for side B: 0 live A, 1 register A |
| src_b2a | input | 1 | Source for side A: 0 live B, 1 register B |
| cap_a_strb | input | 1 | Capture strobe for register A (rising edge) |
| cap_b_strb | input | 1 | Capture strobe for register B (rising edge) |
| a_in | input | W | Word received on side A |
| a_out | output | W | Word presented to side A |
| a_oe | output | W | Per-bit drive enable for side A |
| b_in | input | W | Word received on side B |
| b_out | output | W | Word presented to side B |
| b_oe | output | W | Per-bit drive enable for side B |

## Verification
The hardest situation to reach is a capture made while a side is isolated, or while its stored path is already driving, followed by a replay much later. An output error here shows only some cycles after the edge that caused it. The stimulus latches distinct words into both registers in one isolated clock. It then holds the strobes high with new data to show that no second load happens, and only afterwards switches to stored mode on each side. A separate step raises a strobe while stored mode is driving, so that the old word is seen in the edge cycle and the new word in the cycle after. A sweep over every enable, direction and select combination, driving changing data on both buses and on the strobes, keeps the reference model's shadow registers in step with the design.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_plan_t;

  // Decode the drive controls into which side is driven.
  function automatic drive_plan_t plan_drive(input logic en_n, input logic a2b);
    drive_plan_t p;
    p.drive_a = ~en_n & ~a2b;
    p.drive_b = ~en_n &  a2b;
    return p;
  endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strb,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strb;
  end

  assign rise = strb & ~prev_q;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned W      = 8,
  parameter bit          INVERT = 1'b0
) (
  input  xcvr_pkg::src_sel_e sel,
  input  logic [W-1:0]       live,
  input  logic [W-1:0]       stored,
  output logic [W-1:0]       y
);
  localparam logic [W-1:0] POL_MASK = {W{INVERT}};

  function automatic logic [W-1:0] polarize(input logic [W-1:0] v);
    return v ^ POL_MASK;
  endfunction

  always_comb begin
    unique case (sel)
      xcvr_pkg::SRC_STORED: y = polarize(stored);
      default:              y = polarize(live);
    endcase
  end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         en_n,
  input  logic         a2b,
  output logic [W-1:0] oe_a,
  output logic [W-1:0] oe_b
);
  xcvr_pkg::drive_plan_t plan;

  always_comb begin
    plan = xcvr_pkg::plan_drive(en_n, a2b);
    oe_a = {W{plan.drive_a}};
    oe_b = {W{plan.drive_b}};
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int unsigned W      = 8,
  parameter bit          INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drv_en_n,
  input  logic         dir_a2b,
  input  logic         src_a2b,
  input  logic         src_b2a,
  input  logic         cap_a_strb,
  input  logic         cap_b_strb,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  localparam int unsigned NSIDE = 2;

  // Index 0 is side A, index 1 is side B.
  logic [W-1:0]       side_in  [NSIDE];
  logic               side_strb[NSIDE];
  logic               side_sel [NSIDE];
  logic               cap_evt  [NSIDE];
  logic [W-1:0]       held     [NSIDE];
  logic [W-1:0]       path_y   [NSIDE];

  assign side_in[0]   = a_in;
  assign side_in[1]   = b_in;
  assign side_strb[0] = cap_a_strb;
  assign side_strb[1] = cap_b_strb;
  assign side_sel[0]  = src_a2b;
  assign side_sel[1]  = src_b2a;

  // Path s carries side s toward the opposite side.
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    xcvr_strobe_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .strb (side_strb[s]),
      .rise (cap_evt[s])
    );

    xcvr_store_reg #(.W(W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (cap_evt[s]),
      .d    (side_in[s]),
      .q    (held[s])
    );

    xcvr_path_mux #(.W(W), .INVERT(INVERT)) u_mux (
      .sel    (xcvr_pkg::src_sel_e'(side_sel[s])),
      .live   (side_in[s]),
      .stored (held[s]),
      .y      (path_y[s])
    );
  end

  xcvr_drive_ctrl #(.W(W)) u_drive (
    .en_n (drv_en_n),
    .a2b  (dir_a2b),
    .oe_a (a_oe),
    .oe_b (b_oe)
  );

  assign b_out = path_y[0];
  assign a_out = path_y[1];

  // Named internal events for the checker.
  logic         cap_a_evt, cap_b_evt;
  logic [W-1:0] reg_a_q,   reg_b_q;
  assign cap_a_evt = cap_evt[0];
  assign cap_b_evt = cap_evt[1];
  assign reg_a_q   = held[0];
  assign reg_b_q   = held[1];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned W      = 8,
  parameter bit          INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         drv_en_n,
  input logic         dir_a2b,
  input logic         src_a2b,
  input logic         src_b2a,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic         cap_a_evt,
  input logic         cap_b_evt,
  input logic [W-1:0] reg_a_q,
  input logic [W-1:0] reg_b_q
);
  localparam logic [W-1:0] MASK = {W{INVERT}};

  p_cap_a_r1: assert property (@(posedge clk) disable iff (rst)
    cap_a_evt |=> reg_a_q == $past(a_in));
  p_hold_a_r1: assert property (@(posedge clk) disable iff (rst)
    !cap_a_evt |=> $stable(reg_a_q));
  p_cap_b_r2: assert property (@(posedge clk) disable iff (rst)
    cap_b_evt |=> reg_b_q == $past(b_in));
  p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
    !cap_b_evt |=> $stable(reg_b_q));
  p_iso_cap_r3: assert property (@(posedge clk) disable iff (rst)
    (drv_en_n && cap_a_evt && cap_b_evt) |=>
      (reg_a_q == $past(a_in) && reg_b_q == $past(b_in)));
  p_isolate_r4: assert property (@(posedge clk) disable iff (rst)
    drv_en_n |-> (a_oe == '0 && b_oe == '0));
  p_drive_b_r5: assert property (@(posedge clk) disable iff (rst)
    (!drv_en_n && dir_a2b) |-> (&b_oe && a_oe == '0));
  p_drive_a_r5: assert property (@(posedge clk) disable iff (rst)
    (!drv_en_n && !dir_a2b) |-> (&a_oe && b_oe == '0));
  p_path_ab_r6: assert property (@(posedge clk) disable iff (rst)
    (&b_oe) |-> (b_out == ((src_a2b ? reg_a_q : a_in) ^ MASK)));
  p_path_ba_r7: assert property (@(posedge clk) disable iff (rst)
    (&a_oe) |-> (a_out == ((src_b2a ? reg_b_q : b_in) ^ MASK)));
  p_stored_update_r8: assert property (@(posedge clk) disable iff (rst)
    (&b_oe && src_a2b && cap_a_evt) |=>
      (!(&b_oe && src_a2b) || b_out == ($past(a_in) ^ MASK)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .drv_en_n  (drv_en_n),
  .dir_a2b   (dir_a2b),
  .src_a2b   (src_a2b),
  .src_b2a   (src_b2a),
  .a_in      (a_in),
  .b_in      (b_in),
  .a_out     (a_out),
  .b_out     (b_out),
  .a_oe      (a_oe),
  .b_oe      (b_oe),
  .cap_a_evt (cap_a_evt),
  .cap_b_evt (cap_b_evt),
  .reg_a_q   (reg_a_q),
  .reg_b_q   (reg_b_q)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/100ps
module sim_regbus_xcvr;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst, en_n, a2b, sab, sba, ca, cb;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out0, a_oe0, b_out0, b_oe0;
  logic [W-1:0] a_out1, a_oe1, b_out1, b_oe1;

  regbus_xcvr #(.W(W), .INVERT(1'b0)) u0 (
    .clk(clk), .rst(rst), .drv_en_n(en_n), .dir_a2b(a2b),
    .src_a2b(sab), .src_b2a(sba), .cap_a_strb(ca), .cap_b_strb(cb),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0));

  regbus_xcvr #(.W(W), .INVERT(1'b1)) u1 (
    .clk(clk), .rst(rst), .drv_en_n(en_n), .dir_a2b(a2b),
    .src_a2b(sab), .src_b2a(sba), .cap_a_strb(ca), .cap_b_strb(cb),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1));

  typedef struct {
    logic [W-1:0] a_oe, b_oe, a_val, b_val;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: shadow registers and strobe history.
  logic [W-1:0] m_ra = '0, m_rb = '0;
  logic         m_pa = 1'b0, m_pb = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic d,
                      input logic s1, input logic s2, input logic c1,
                      input logic c2, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; en_n = e; a2b = d; sab = s1; sba = s2;
    ca = c1; cb = c2; a_in = a; b_in = b;
    x.b_oe  = {W{~e & d}};
    x.a_oe  = {W{~e & ~d}};
    x.b_val = s1 ? m_ra : a;
    x.a_val = s2 ? m_rb : b;
    x.tag   = tag;
    q.push_back(x);
    @(posedge clk);
    if (r) begin
      m_ra = '0; m_rb = '0; m_pa = 1'b0; m_pb = 1'b0;
    end else begin
      if (c1 && !m_pa) m_ra = a;
      if (c2 && !m_pb) m_rb = b;
      m_pa = c1; m_pb = c2;
    end
  endtask

  // Monitor: compares each queued expectation with both variants.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check(a_oe0 == x.a_oe && a_oe1 == x.a_oe, x.tag, "a_oe", a_oe0, x.a_oe);
        check(b_oe0 == x.b_oe && b_oe1 == x.b_oe, x.tag, "b_oe", b_oe0, x.b_oe);
        if (&x.b_oe) begin
          check(b_out0 == x.b_val, x.tag, "b_out", b_out0, x.b_val);
          check(b_out1 == ~x.b_val, {x.tag, "/R9"}, "b_out inv", b_out1, ~x.b_val);
        end
        if (&x.a_oe) begin
          check(a_out0 == x.a_val, x.tag, "a_out", a_out0, x.a_val);
          check(a_out1 == ~x.a_val, {x.tag, "/R9"}, "a_out inv", a_out1, ~x.a_val);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R10: reset with strobe A held high
    step(1, 1, 0, 0, 0, 1, 0, 8'h3C, 8'h00, "R10 reset iso");
    step(1, 0, 1, 1, 0, 1, 0, 8'h3C, 8'h00, "R10 reset clears A");
    step(1, 0, 0, 0, 1, 1, 0, 8'h3C, 8'h00, "R10 reset clears B");
    // first clock after reset: high strobe counts as edge
    step(0, 1, 0, 0, 0, 1, 0, 8'h3C, 8'h00, "R10 edge after reset");
    step(0, 0, 1, 1, 0, 1, 0, 8'h99, 8'h00, "R10 stored after reset");
    step(0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R4 idle");
    // R3: both captured in one isolated clock
    step(0, 1, 1, 1, 1, 1, 1, 8'h5A, 8'hC3, "R3 iso capture both");
    // R1/R2: strobes held high, new data must not load
    step(0, 1, 0, 0, 0, 1, 1, 8'h11, 8'h22, "R1 R2 held strobe");
    step(0, 0, 1, 1, 0, 1, 1, 8'h11, 8'h22, "R1 R6 stored A");
    step(0, 0, 0, 0, 1, 0, 0, 8'h11, 8'h22, "R2 R7 stored B");
    // R6/R7 transparent with several patterns
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, 0, 0, 0, 0, W'(8'h01 << i), 8'hFF, "R5 R6 live A to B");
      step(0, 0, 0, 0, 0, 0, 0, 8'h00, W'(~(8'h80 >> i)), "R5 R7 live B to A");
    end
    // R8: capture while stored path drives
    step(0, 0, 1, 1, 0, 0, 0, 8'h77, 8'h00, "R8 before edge");
    step(0, 0, 1, 1, 0, 1, 0, 8'h77, 8'h00, "R8 edge cycle old");
    step(0, 0, 1, 1, 0, 1, 0, 8'h88, 8'h00, "R8 next cycle new");
    step(0, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R8 B before");
    step(0, 0, 0, 0, 1, 0, 1, 8'h00, 8'hE4, "R8 B edge old");
    step(0, 0, 0, 0, 1, 0, 1, 8'h00, 8'h1B, "R8 B next new");
    // Sweep: every enable, direction and select combination
    for (int k = 0; k < 64; k++) begin
      logic [3:0] c;
      c = 4'(k);
      step(0, c[3], c[2], c[1], c[0], k[4], k[5],
           W'(k * 37 + 5), W'(k * 91 + 13), "R3 R4 R5 R6 R7 sweep");
    end
    step(0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R4 final");
    @(negedge clk);
    #2;
    finish_run();
  end
endmodule